// File: doc/BRIEF.md
# Sleep-Mode Wake Detector

This block watches a sleeping transceiver's inputs and decides when the node should wake. It has two independent sources. The first is the shared bus, seen through two digitized comparator flags: one says the level is below the pre-wake threshold, the other says it is dominant. The second is a local wake pin, which is active low. Each source has its own debounce timer and its own rule for arming again after an event. Each source reports a wake with a single-cycle pulse.

A remote wake is accepted only for a specific sequence. The bus must fall below pre-wake, then hold dominant for a filter time, then return to recessive. While the bus sits below pre-wake, a receiver-active flag is raised. A monitor timer limits how long that flag can stay up. If the monitor runs out while the bus is only part-way low, detection gives up. If it runs out while the bus is still dominant, as with a short to ground, the detector stops monitoring and waits. A later return to recessive then wakes the node at once.

All durations are counted in ticks of a microsecond timebase input. Detection runs only while the mode input reports sleep. Outside sleep, every timer and state is held at its starting point.

Top module: `sleep_wake_detector`

## Requirements
- R1: While `sleep_mode` is 0, and in the cycle after it drops, `remote_wake`, `local_wake` and `rx_active` are 0. On each return to sleep, both sources start from their re-arm state with their counters cleared.
- R2: When the bus is armed, the first cycle with `bus_below_prewake`=1 raises `rx_active` at the next clock edge.
- R3: If `bus_dominant` is held for `BUS_FILT_TICKS` ticks during an active window and the bus then goes recessive (`bus_below_prewake`=0), `remote_wake` pulses high for exactly one cycle, at the clock edge after the rise.
- R4: A dominant phase shorter than `BUS_FILT_TICKS` ticks, followed by recessive, produces no `remote_wake`. Any gap in dominance restarts the dominant count.
- R5: If `MON_TICKS` ticks pass in an active window without a qualified wake, and the bus is below pre-wake but not dominant, `rx_active` drops and no wake is produced.
- R6: If the monitor expires while the bus is dominant, `rx_active` drops with no pulse. The next return to recessive then produces a one-cycle `remote_wake`.
- R7: After any return to recessive or any monitor timeout, the bus must stay recessive for `BUS_REARM_TICKS` ticks before a new fall below pre-wake starts detection. An earlier fall leaves `rx_active` at 0.
- R8: Once the pin is armed, if `wake_pin` goes low (0) and stays low for `WAKE_FILT_TICKS` ticks, `local_wake` pulses high for one cycle.
- R9: A low on `wake_pin` that returns high before `WAKE_FILT_TICKS` ticks produces no `local_wake`.
- R10: After a local wake, and on entry to sleep, the pin must be high (1) for `WAKE_REARM_TICKS` ticks before a new falling edge can start the filter. A continuous low, or a shorter high, gives no further pulse.
- R11: Timers advance only in cycles where `us_tick` is 1. With no ticks, no filter or monitor completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle timebase strobe, one per microsecond |
| sleep_mode | input | 1 | 1 while the node is in sleep; enables detection |
| bus_below_prewake | input | 1 | Bus level is below the pre-wake threshold |
| bus_dominant | input | 1 | Bus level is below the dominant threshold |
| wake_pin | input | 1 | Local wake input, active low |
| remote_wake | output | 1 | One-cycle pulse on a qualified bus wake |
| local_wake | output | 1 | One-cycle pulse on a qualified pin wake |
| rx_active | output | 1 | Bus receiver enabled for wake monitoring |

## Verification
Every result is registered, so it appears at the first clock edge after the input cycle that decides it. A pin or bus change that completes a filter shows its pulse one cycle later. The tick that completes a filter, monitor or re-arm count takes effect at that same edge. The bench drives inputs on the falling clock edge, and a behavioural model advances on the rising edge from the same inputs. All three outputs are compared with the model on every falling edge, half a cycle after they settle. Scenario checks also compare the number of pulses in each phase, and `rx_active` at chosen points, against counts worked out by hand.

// File: rtl/wake_det_pkg.sv
package wake_det_pkg;

    typedef enum logic [2:0] {
        BUS_REARM     = 3'd0,
        BUS_IDLE      = 3'd1,
        BUS_FILTER    = 3'd2,
        BUS_QUALIFIED = 3'd3,
        BUS_STUCK     = 3'd4
    } bus_state_e;

    typedef enum logic [1:0] {
        PIN_REARM  = 2'd0,
        PIN_IDLE   = 2'd1,
        PIN_FILTER = 2'd2
    } pin_state_e;

    typedef struct packed {
        logic below_prewake;
        logic dominant;
    } bus_level_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/wake_tick_counter.sv
module wake_tick_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic hit
);
    localparam int W = wake_det_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);
    localparam logic [W-1:0] TOP  = W'(LIMIT);

    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (tick && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    assign hit = !clear && tick && (count == LAST);

endmodule

// File: rtl/bus_wake_fsm.sv
module bus_wake_fsm
    import wake_det_pkg::*;
#(
    parameter int BUS_FILT_TICKS  = 90,
    parameter int MON_TICKS       = 10000,
    parameter int BUS_REARM_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sleep,
    input  bus_level_t lvl,
    output logic       wake_pulse,
    output logic       rx_on
);
    bus_state_e state, state_n;
    logic pulse_n;
    logic arm_hit, dom_hit, mon_hit;
    logic arm_clr, dom_clr, mon_clr;
    logic in_window;

    assign in_window = (state == BUS_FILTER) || (state == BUS_QUALIFIED);
    assign arm_clr   = !sleep || state != BUS_REARM || lvl.below_prewake;
    assign dom_clr   = !sleep || state != BUS_FILTER || !lvl.dominant;
    assign mon_clr   = !sleep || !in_window;

    wake_tick_counter #(.LIMIT(BUS_REARM_TICKS)) u_arm (
        .clk(clk), .rst(rst), .clear(arm_clr), .tick(tick), .hit(arm_hit));
    wake_tick_counter #(.LIMIT(BUS_FILT_TICKS)) u_dom (
        .clk(clk), .rst(rst), .clear(dom_clr), .tick(tick), .hit(dom_hit));
    wake_tick_counter #(.LIMIT(MON_TICKS)) u_mon (
        .clk(clk), .rst(rst), .clear(mon_clr), .tick(tick), .hit(mon_hit));

    always_comb begin
        state_n = state;
        pulse_n = 1'b0;
        unique case (state)
            BUS_REARM: if (arm_hit) state_n = BUS_IDLE;
            BUS_IDLE:  if (lvl.below_prewake) state_n = BUS_FILTER;
            BUS_FILTER: begin
                if (!lvl.below_prewake)  state_n = BUS_REARM;
                else if (dom_hit)        state_n = BUS_QUALIFIED;
                else if (mon_hit)        state_n = lvl.dominant ? BUS_STUCK : BUS_REARM;
            end
            BUS_QUALIFIED: begin
                if (!lvl.below_prewake) begin
                    state_n = BUS_REARM;
                    pulse_n = 1'b1;
                end else if (mon_hit) begin
                    state_n = lvl.dominant ? BUS_STUCK : BUS_REARM;
                end
            end
            BUS_STUCK: begin
                if (!lvl.below_prewake) begin
                    state_n = BUS_REARM;
                    pulse_n = 1'b1;
                end
            end
            default: state_n = BUS_REARM;
        endcase
        if (!sleep) begin
            state_n = BUS_REARM;
            pulse_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= BUS_REARM;
            wake_pulse <= 1'b0;
        end else begin
            state      <= state_n;
            wake_pulse <= pulse_n;
        end
    end

    assign rx_on = in_window;

    // window tick tally used only by the monitor-bound assertion
    logic [wake_det_pkg::cnt_width(MON_TICKS + 1)-1:0] win_ticks;
    always_ff @(posedge clk) begin
        if (rst || !rx_on) win_ticks <= '0;
        else if (tick)     win_ticks <= win_ticks + 1'b1;
    end

    // R3
    bus_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    // R3
    bus_pulse_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> !$past(lvl.below_prewake));
    // R1
    bus_quiet_outside_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        !sleep |=> (!wake_pulse && !rx_on));
    // R5
    bus_monitor_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rx_on |-> (int'(win_ticks) <= MON_TICKS));
    // R2
    bus_rx_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_on) |-> $past(lvl.below_prewake));

endmodule

// File: rtl/pin_wake_fsm.sv
module pin_wake_fsm
    import wake_det_pkg::*;
#(
    parameter int WAKE_FILT_TICKS  = 35,
    parameter int WAKE_REARM_TICKS = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sleep,
    input  logic pin_high,
    output logic wake_pulse
);
    pin_state_e state, state_n;
    logic pulse_n;
    logic arm_hit, filt_hit, arm_clr, filt_clr;

    assign arm_clr  = !sleep || state != PIN_REARM || !pin_high;
    assign filt_clr = !sleep || state != PIN_FILTER || pin_high;

    wake_tick_counter #(.LIMIT(WAKE_REARM_TICKS)) u_arm (
        .clk(clk), .rst(rst), .clear(arm_clr), .tick(tick), .hit(arm_hit));
    wake_tick_counter #(.LIMIT(WAKE_FILT_TICKS)) u_filt (
        .clk(clk), .rst(rst), .clear(filt_clr), .tick(tick), .hit(filt_hit));

    always_comb begin
        state_n = state;
        pulse_n = 1'b0;
        unique case (state)
            PIN_REARM: if (arm_hit) state_n = PIN_IDLE;
            PIN_IDLE:  if (!pin_high) state_n = PIN_FILTER;
            PIN_FILTER: begin
                if (pin_high) begin
                    state_n = PIN_REARM;
                end else if (filt_hit) begin
                    state_n = PIN_REARM;
                    pulse_n = 1'b1;
                end
            end
            default: state_n = PIN_REARM;
        endcase
        if (!sleep) begin
            state_n = PIN_REARM;
            pulse_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PIN_REARM;
            wake_pulse <= 1'b0;
        end else begin
            state      <= state_n;
            wake_pulse <= pulse_n;
        end
    end

    // R10
    pin_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    // R8
    pin_pulse_while_low_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> !$past(pin_high));
    // R11
    pin_pulse_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(tick));
    // R1
    pin_quiet_outside_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        !sleep |=> !wake_pulse);

endmodule

// File: rtl/sleep_wake_detector.sv
module sleep_wake_detector
    import wake_det_pkg::*;
#(
    parameter int BUS_FILT_TICKS   = 90,
    parameter int MON_TICKS        = 10000,
    parameter int BUS_REARM_TICKS  = 3,
    parameter int WAKE_FILT_TICKS  = 35,
    parameter int WAKE_REARM_TICKS = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic sleep_mode,
    input  logic bus_below_prewake,
    input  logic bus_dominant,
    input  logic wake_pin,
    output logic remote_wake,
    output logic local_wake,
    output logic rx_active
);
    bus_level_t lvl;
    assign lvl = '{below_prewake: bus_below_prewake, dominant: bus_dominant};

    initial begin
        if (BUS_FILT_TICKS < 1 || BUS_FILT_TICKS >= MON_TICKS)
            $error("bus filter must be at least 1 and below the monitor time");
        if (BUS_REARM_TICKS < 1 || WAKE_FILT_TICKS < 1 || WAKE_REARM_TICKS < 1)
            $error("tick counts must be at least 1");
    end

    bus_wake_fsm #(
        .BUS_FILT_TICKS(BUS_FILT_TICKS),
        .MON_TICKS(MON_TICKS),
        .BUS_REARM_TICKS(BUS_REARM_TICKS)
    ) u_bus (
        .clk(clk), .rst(rst), .tick(us_tick), .sleep(sleep_mode),
        .lvl(lvl), .wake_pulse(remote_wake), .rx_on(rx_active));

    pin_wake_fsm #(
        .WAKE_FILT_TICKS(WAKE_FILT_TICKS),
        .WAKE_REARM_TICKS(WAKE_REARM_TICKS)
    ) u_pin (
        .clk(clk), .rst(rst), .tick(us_tick), .sleep(sleep_mode),
        .pin_high(wake_pin), .wake_pulse(local_wake));

endmodule

// File: tb/sim_sleep_wake_detector.sv
module sim_sleep_wake_detector;
    localparam int P_BF = 6, P_MON = 30, P_BR = 2, P_WF = 5, P_WR = 3;

    logic clk = 0, rst = 1, tick = 0, tick_en = 1;
    logic sleep = 0, pw = 0, dom = 0, pin = 1;
    logic remote_wake, local_wake, rx_active;

    always #2.5 clk = ~clk;

    sleep_wake_detector #(.BUS_FILT_TICKS(P_BF), .MON_TICKS(P_MON),
        .BUS_REARM_TICKS(P_BR), .WAKE_FILT_TICKS(P_WF), .WAKE_REARM_TICKS(P_WR)) u0 (
        .clk(clk), .rst(rst), .us_tick(tick), .sleep_mode(sleep),
        .bus_below_prewake(pw), .bus_dominant(dom), .wake_pin(pin),
        .remote_wake(remote_wake), .local_wake(local_wake), .rx_active(rx_active));

    int n_checks = 0, n_fail = 0;
    int rem_cnt = 0, loc_cnt = 0;
    string cur_req = "R1";
    bit started = 0;

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: integer phase codes, not the RTL's encoding
    int b_ph = 0, b_arm = 0, b_mon = 0, b_dom = 0;
    int p_ph = 0, p_cnt = 0;
    int m_rw = 0, m_lw = 0;

    always @(posedge clk) begin
        int rw, lw;
        rw = 0; lw = 0;
        if (rst || !sleep) begin
            b_ph = 0; b_arm = 0; b_mon = 0; b_dom = 0; p_ph = 0; p_cnt = 0;
        end else begin
            if (b_ph == 0) begin
                if (pw) b_arm = 0;
                else if (tick) begin
                    b_arm++;
                    if (b_arm >= P_BR) begin b_ph = 1; b_arm = 0; end
                end
            end else if (b_ph == 1) begin
                if (pw) begin b_ph = 2; b_mon = 0; b_dom = 0; end
            end else if (b_ph == 2) begin
                if (!pw) begin b_ph = 0; b_arm = 0; end
                else begin
                    if (!dom) b_dom = 0;
                    if (tick) begin
                        b_mon++;
                        if (dom) b_dom++;
                        if (b_dom >= P_BF) b_ph = 3;
                        else if (b_mon >= P_MON) begin b_ph = dom ? 4 : 0; b_arm = 0; end
                    end
                end
            end else if (b_ph == 3) begin
                if (!pw) begin rw = 1; b_ph = 0; b_arm = 0; end
                else if (tick) begin
                    b_mon++;
                    if (b_mon >= P_MON) begin b_ph = dom ? 4 : 0; b_arm = 0; end
                end
            end else begin
                if (!pw) begin rw = 1; b_ph = 0; b_arm = 0; end
            end

            if (p_ph == 0) begin
                if (!pin) p_cnt = 0;
                else if (tick) begin
                    p_cnt++;
                    if (p_cnt >= P_WR) begin p_ph = 1; p_cnt = 0; end
                end
            end else if (p_ph == 1) begin
                if (!pin) begin p_ph = 2; p_cnt = 0; end
            end else begin
                if (pin) begin p_ph = 0; p_cnt = 0; end
                else if (tick) begin
                    p_cnt++;
                    if (p_cnt >= P_WF) begin lw = 1; p_ph = 0; p_cnt = 0; end
                end
            end
        end
        m_rw = rw; m_lw = lw;
        if (!rst) started = 1;
    end

    // drive tick, compare every cycle on the falling edge
    always @(negedge clk) begin
        tick = tick_en ? ~tick : 1'b0;
        if (started) begin
            check({cur_req, " remote_wake"}, int'(remote_wake), m_rw);
            check({cur_req, " local_wake"}, int'(local_wake), m_lw);
            check({cur_req, " rx_active"}, int'(rx_active), int'(b_ph == 2 || b_ph == 3));
            if (remote_wake) rem_cnt++;
            if (local_wake)  loc_cnt++;
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus(logic below, logic d);
        pw = below; dom = d;
    endtask

    initial begin
        bit done = 0;
        fork
            begin
                run(3);
                check("R1 reset remote", int'(remote_wake), 0);
                check("R1 reset local", int'(local_wake), 0);
                check("R1 reset rx", int'(rx_active), 0);
                rst = 0;
                run(10);
                check("R1 awake rx", int'(rx_active), 0);

                sleep = 1; cur_req = "R3"; run(20);
                rem_cnt = 0; bus(1, 1); run(1);
                check("R2 rx after fall", int'(rx_active), 1);
                run(19); bus(0, 0); run(20);
                check("R3 remote pulses", rem_cnt, 1);

                cur_req = "R4"; rem_cnt = 0;
                bus(1, 1); run(6); bus(1, 0); run(2); bus(1, 1); run(6); bus(0, 0); run(20);
                check("R4 short dominant pulses", rem_cnt, 0);

                cur_req = "R5"; rem_cnt = 0;
                bus(1, 0); run(80);
                check("R5 rx after monitor", int'(rx_active), 0);
                check("R5 pulses", rem_cnt, 0);
                cur_req = "R7";
                bus(0, 0); run(1); bus(1, 1); run(2);
                check("R7 early fall rx", int'(rx_active), 0);
                run(18); bus(0, 0); run(20);
                check("R7 pulses", rem_cnt, 0);

                cur_req = "R6"; rem_cnt = 0;
                bus(1, 1); run(80);
                check("R6 rx after monitor", int'(rx_active), 0);
                check("R6 no pulse while stuck", rem_cnt, 0);
                bus(0, 0); run(2);
                check("R6 pulse on rise", rem_cnt, 1);
                run(20);

                cur_req = "R8"; loc_cnt = 0;
                pin = 0; run(14);
                check("R8 local pulses", loc_cnt, 1);
                cur_req = "R10";
                run(40);
                check("R10 continuous low", loc_cnt, 1);
                pin = 1; run(2); pin = 0; run(14);
                check("R10 short high", loc_cnt, 1);
                pin = 1; run(20);
                cur_req = "R9";
                pin = 0; run(4); pin = 1; run(20);
                check("R9 short low", loc_cnt, 1);

                cur_req = "R11"; rem_cnt = 0; loc_cnt = 0;
                tick_en = 0; run(1);
                bus(1, 1); pin = 0; run(40);
                check("R11 rx held without ticks", int'(rx_active), 1);
                bus(0, 0); pin = 1; run(5);
                check("R11 remote pulses", rem_cnt, 0);
                check("R11 local pulses", loc_cnt, 0);
                tick_en = 1; run(20);

                cur_req = "R1"; loc_cnt = 0; rem_cnt = 0;
                bus(1, 1); run(8); sleep = 0; run(1);
                check("R1 rx after leaving sleep", int'(rx_active), 0);
                run(30); bus(0, 0); run(5);
                check("R1 no remote outside sleep", rem_cnt, 0);
                cur_req = "R10"; pin = 0; run(5); sleep = 1; run(40);
                check("R10 sleep entry with pin low", loc_cnt, 0);
                pin = 1; run(20); pin = 0; run(14);
                check("R10 after rearm", loc_cnt, 1);
                done = 1;
            end
            begin
                run(100000);
                if (!done) begin
                    n_checks++; n_fail++;
                    $display("FAIL watchdog: actual hung expected finished");
                end
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule